// File: doc/BRIEF.md
# Wakeup Event Aggregator

This block gathers the low-power wakeup requests of a chip into a single wakeup pulse for the power state machine. It has five inputs. Two are already-filtered wakeup pin levels. One is an RTC alarm, one is a button-control event, and one marks a hardware reset. A per-source enable register, loaded through bitmap set and clear writes, gates the inputs. The two pins can be merged with OR or with AND.

The power state machine reports its state on a two-bit code. The block issues wakeups only while that code says OFF. An event that arrives in the RTC state is either dropped, or held and released once OFF is reached, depending on a mode input. Every wakeup that is issued records its cause in a sticky source register. Software reads that register and clears it with a write-one-to-clear command.

Top module: `wake_aggregator`

## Requirements
- R1: A set write ORs `en_bits` into the enable mask and leaves every other bit as it was. Mask bit0 enables pin 0, bit1 enables pin 1, bit2 enables the RTC source and bit3 enables the button source. The mask appears on `en_mask` one edge after the write.
- R2: A clear write removes the bits in `en_bits` from the mask and leaves all other bits unchanged. When set and clear happen in the same cycle, the clear wins for the bits it names.
- R3: With `pin_and_mode` low, either enabled pin being high is a pin wakeup.
- R4: With `pin_and_mode` high, a pin wakeup needs both pins enabled and both high in the same cycle. One pin alone gives nothing.
- R5: A pin, RTC or button source whose mask bit is clear produces no wakeup and sets no source bit.
- R6: In the OFF state (`pm_state` = 2), `wake_pulse` is high for exactly one cycle, on the edge after the combined request rises. A request held high gives no second pulse until it drops.
- R7: In the RTC state (`pm_state` = 1), `wake_pulse` stays low.
- R8: With `latch_mode` low, events seen in the RTC state are discarded. Entering OFF afterwards gives no pulse and no source bit.
- R9: With `latch_mode` high, events seen in the RTC state are held. The pulse comes on the edge after the first OFF cycle, and the held sources are recorded in `wake_src` at that same edge.
- R10: The bits of `wake_src` are: bit0 button, bit1 RTC, bit2 pin, bit3 hardware reset. The hardware reset input is not gated by the mask.
- R11: `wake_src` bits stay set until a clear command names them (`src_clr_vld` with a 1 in `src_clr_bits`). If a new event arrives in the same cycle as the clear, the bit stays set.
- R12: In the RUN state (`pm_state` = 0) and in code 3, events are neither issued nor held.
- R13: After reset, `en_mask`, `wake_src` and `wake_pulse` are all zero, and nothing is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set_vld | input | 1 | Set write strobe for the enable mask |
| en_clr_vld | input | 1 | Clear write strobe for the enable mask |
| en_bits | input | 4 | Bitmap used by the set or clear write |
| pin_and_mode | input | 1 | 1: both pins required; 0: either pin |
| latch_mode | input | 1 | 1: hold events seen in RTC state; 0: drop them |
| pm_state | input | 2 | Power state: 0 RUN, 1 RTC, 2 OFF, 3 reserved |
| pin0_evt | input | 1 | Filtered wakeup pin 0 level |
| pin1_evt | input | 1 | Filtered wakeup pin 1 level |
| rtc_evt | input | 1 | RTC alarm event |
| btn_evt | input | 1 | Button-control event |
| hwrst_evt | input | 1 | Hardware reset indication |
| src_clr_vld | input | 1 | Source register clear command |
| src_clr_bits | input | 4 | Source bits to clear |
| en_mask | output | 4 | Current enable mask |
| wake_src | output | 4 | Sticky wakeup source register |
| wake_pulse | output | 1 | One-cycle wakeup to the power state machine |

## Verification
Every result of this block is due one rising edge after the inputs that cause it are sampled. The mask follows a write by one edge. The pulse and the source bits follow a request in OFF by one edge. An event held from the RTC state is released on the edge after the first OFF cycle. The bench changes inputs only on the falling edge and pushes the value expected after the next rising edge into a queue at that moment. A monitor pops and compares each item 2 ns after that rising edge, so every comparison lands in the cycle where the registered outputs have just settled.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int SRC_W  = 4;  // width of the source register
  localparam int MASK_W = 4;  // width of the enable mask
  localparam int ST_W   = 2;  // width of the power state code

  // enable mask bit positions
  localparam int EN_PIN0 = 0;
  localparam int EN_PIN1 = 1;
  localparam int EN_RTC  = 2;
  localparam int EN_BTN  = 3;

  // source register bit positions
  localparam int SRC_BTN = 0;
  localparam int SRC_RTC = 1;
  localparam int SRC_PIN = 2;
  localparam int SRC_HW  = 3;

  typedef enum logic [ST_W-1:0] {
    PM_RUN  = 2'd0,
    PM_RTC  = 2'd1,
    PM_OFF  = 2'd2,
    PM_RSVD = 2'd3
  } pm_state_e;
endpackage

// File: rtl/wk_enable_reg.sv
module wk_enable_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_vld,
  input  logic         clr_vld,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);
  logic [W-1:0] set_part;
  logic [W-1:0] keep_part;

  always_comb begin
    set_part  = set_vld ? bits : '0;
    keep_part = clr_vld ? ~bits : '1;
  end

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else     mask <= (mask | set_part) & keep_part;
  end

  // R1: without a write the mask keeps its value
  p_mask_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!set_vld && !clr_vld) |=> $stable(mask));

  // R2: bits named by a clear are gone on the next edge
  p_clr_wins_r2: assert property (@(posedge clk) disable iff (rst)
    clr_vld |=> ((mask & $past(bits)) == '0));
endmodule

// File: rtl/wk_combine.sv
module wk_combine
  import wk_pkg::*;
(
  input  logic [MASK_W-1:0] mask,
  input  logic              and_mode,
  input  logic              pin0,
  input  logic              pin1,
  input  logic              rtc,
  input  logic              btn,
  input  logic              hwrst,
  output logic [SRC_W-1:0]  ev
);
  logic p0_hit, p1_hit, pin_hit;

  always_comb begin
    p0_hit  = mask[EN_PIN0] & pin0;
    p1_hit  = mask[EN_PIN1] & pin1;
    pin_hit = and_mode ? (p0_hit & p1_hit) : (p0_hit | p1_hit);
    ev          = '0;
    ev[SRC_BTN] = mask[EN_BTN] & btn;
    ev[SRC_RTC] = mask[EN_RTC] & rtc;
    ev[SRC_PIN] = pin_hit;
    ev[SRC_HW]  = hwrst;
  end
endmodule

// File: rtl/wk_release.sv
module wk_release
  import wk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ST_W-1:0]  state,
  input  logic             latch_mode,
  input  logic [SRC_W-1:0] ev,
  input  logic             src_clr_vld,
  input  logic [SRC_W-1:0] src_clr_bits,
  output logic             wake_pulse,
  output logic [SRC_W-1:0] wake_src
);
  pm_state_e        st;
  logic [SRC_W-1:0] pend;
  logic [SRC_W-1:0] rel_bits;
  logic [SRC_W-1:0] clr_mask;
  logic             req, req_q;

  always_comb begin
    st       = pm_state_e'(state);
    rel_bits = (st == PM_OFF) ? (ev | pend) : '0;
    req      = |rel_bits;
    clr_mask = src_clr_vld ? src_clr_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= '0;
      req_q      <= 1'b0;
      wake_pulse <= 1'b0;
      wake_src   <= '0;
    end else begin
      req_q      <= req;
      wake_pulse <= req & ~req_q;
      wake_src   <= (wake_src & ~clr_mask) | rel_bits;
      case (st)
        PM_OFF:  pend <= '0;
        PM_RTC:  if (latch_mode) pend <= pend | ev;
        default: pend <= pend;
      endcase
    end
  end

  // R7: a cycle spent in RTC state never yields a pulse
  p_rtc_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (st == PM_RTC) |=> !wake_pulse);

  // R6: the pulse lasts one cycle
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  // R11: source bits only fall through a clear command
  p_src_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    !src_clr_vld |=> ((wake_src & $past(wake_src)) == $past(wake_src)));

  // R8: in drop mode nothing is collected in RTC state
  p_drop_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (!latch_mode && st == PM_RTC && pend == '0) |=> (pend == '0));

  // R9: held events leave as a pulse after OFF is seen
  p_held_release_r9: assert property (@(posedge clk) disable iff (rst)
    (st == PM_OFF && pend != '0 && !req_q) |=> wake_pulse);
endmodule

// File: rtl/wake_aggregator.sv
module wake_aggregator
  import wk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_set_vld,
  input  logic              en_clr_vld,
  input  logic [MASK_W-1:0] en_bits,
  input  logic              pin_and_mode,
  input  logic              latch_mode,
  input  logic [ST_W-1:0]   pm_state,
  input  logic              pin0_evt,
  input  logic              pin1_evt,
  input  logic              rtc_evt,
  input  logic              btn_evt,
  input  logic              hwrst_evt,
  input  logic              src_clr_vld,
  input  logic [SRC_W-1:0]  src_clr_bits,
  output logic [MASK_W-1:0] en_mask,
  output logic [SRC_W-1:0]  wake_src,
  output logic              wake_pulse
);
  logic [SRC_W-1:0] ev;

  wk_enable_reg #(.W(MASK_W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .set_vld (en_set_vld),
    .clr_vld (en_clr_vld),
    .bits    (en_bits),
    .mask    (en_mask)
  );

  wk_combine u_comb (
    .mask     (en_mask),
    .and_mode (pin_and_mode),
    .pin0     (pin0_evt),
    .pin1     (pin1_evt),
    .rtc      (rtc_evt),
    .btn      (btn_evt),
    .hwrst    (hwrst_evt),
    .ev       (ev)
  );

  wk_release u_rel (
    .clk          (clk),
    .rst          (rst),
    .state        (pm_state),
    .latch_mode   (latch_mode),
    .ev           (ev),
    .src_clr_vld  (src_clr_vld),
    .src_clr_bits (src_clr_bits),
    .wake_pulse   (wake_pulse),
    .wake_src     (wake_src)
  );

  // R5: a masked-off button source never reaches the source register
  p_btn_gated_r5: assert property (@(posedge clk) disable iff (rst)
    (!en_mask[EN_BTN] && !wake_src[SRC_BTN]) |=> !wake_src[SRC_BTN]);
endmodule

// File: tb/wake_aggregator_bench.sv
`timescale 1ns/1ps
module wake_aggregator_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_set_vld = 0, en_clr_vld = 0;
  logic [3:0] en_bits = 0;
  logic pin_and_mode = 0, latch_mode = 0;
  logic [1:0] pm_state = 0;
  logic pin0_evt = 0, pin1_evt = 0, rtc_evt = 0, btn_evt = 0, hwrst_evt = 0;
  logic src_clr_vld = 0;
  logic [3:0] src_clr_bits = 0;
  logic [3:0] en_mask, wake_src;
  logic wake_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic       wake;
    logic [3:0] src;
    logic [3:0] mask;
    string      tag;
  } exp_t;
  exp_t sb_q[$];
  exp_t got;

  // expectation model state, built from the requirements
  logic [3:0] m_mask = 0, m_src = 0, m_hold = 0;
  logic       m_req_q = 0;

  always #5 clk = ~clk;

  wake_aggregator u_wake_aggregator (
    .clk(clk), .rst(rst), .en_set_vld(en_set_vld), .en_clr_vld(en_clr_vld),
    .en_bits(en_bits), .pin_and_mode(pin_and_mode), .latch_mode(latch_mode),
    .pm_state(pm_state), .pin0_evt(pin0_evt), .pin1_evt(pin1_evt),
    .rtc_evt(rtc_evt), .btn_evt(btn_evt), .hwrst_evt(hwrst_evt),
    .src_clr_vld(src_clr_vld), .src_clr_bits(src_clr_bits),
    .en_mask(en_mask), .wake_src(wake_src), .wake_pulse(wake_pulse)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] expv, input string what, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: compare one item just after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      got = sb_q.pop_front();
      chk({3'b0, wake_pulse}, {3'b0, got.wake}, "wake_pulse", got.tag);
      chk(wake_src, got.src, "wake_src", got.tag);
      chk(en_mask, got.mask, "en_mask", got.tag);
    end
  end

  // driver step: inputs are already set; predict the next edge and wait for it
  task automatic tick(input string tag);
    logic [3:0] ev, rel, nmask;
    logic p0, p1, pin, req;
    exp_t e;
    p0  = m_mask[0] & pin0_evt;
    p1  = m_mask[1] & pin1_evt;
    pin = pin_and_mode ? (p0 & p1) : (p0 | p1);
    ev  = {hwrst_evt, pin, m_mask[2] & rtc_evt, m_mask[3] & btn_evt};
    nmask = m_mask;
    if (en_set_vld) nmask = nmask | en_bits;
    if (en_clr_vld) nmask = nmask & ~en_bits;
    rel = (pm_state == 2'd2) ? (ev | m_hold) : 4'h0;
    req = |rel;
    e.wake = req & ~m_req_q;
    e.src  = (src_clr_vld ? (m_src & ~src_clr_bits) : m_src) | rel;
    e.mask = nmask;
    e.tag  = tag;
    if (pm_state == 2'd2) m_hold = 4'h0;
    else if (pm_state == 2'd1 && latch_mode) m_hold = m_hold | ev;
    m_req_q = req;
    m_src   = e.src;
    m_mask  = nmask;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic mset(input logic [3:0] b, input string tag);
    en_set_vld = 1; en_bits = b; tick(tag); en_set_vld = 0;
  endtask

  task automatic mclr(input logic [3:0] b, input string tag);
    en_clr_vld = 1; en_bits = b; tick(tag); en_clr_vld = 0;
  endtask

  task automatic sclr(input logic [3:0] b, input string tag);
    src_clr_vld = 1; src_clr_bits = b; tick(tag); src_clr_vld = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk({3'b0, wake_pulse}, 4'h0, "wake_pulse", "R13");
    chk(wake_src, 4'h0, "wake_src", "R13");
    chk(en_mask, 4'h0, "en_mask", "R13");

    mset(4'b0101, "R1 set");
    mset(4'b1000, "R1 set keeps others");
    mclr(4'b0001, "R2 clear");
    en_set_vld = 1; en_clr_vld = 1; en_bits = 4'b0011;
    tick("R2 clear wins"); en_set_vld = 0; en_clr_vld = 0;
    mset(4'b1111, "R1 set all");

    pm_state = 2'd2;
    pin0_evt = 1; idle(4, "R3 R6 pin0 held");
    pin0_evt = 0; idle(1, "R6 drop");
    sclr(4'hF, "R11 clear all");
    pin1_evt = 1; idle(2, "R3 pin1");
    pin1_evt = 0; sclr(4'b0100, "R11 clear pin");
    pin_and_mode = 1;
    pin0_evt = 1; idle(3, "R4 one pin only");
    pin1_evt = 1; idle(2, "R4 both pins");
    pin0_evt = 0; pin1_evt = 0; sclr(4'hF, "R11 clear");
    pin_and_mode = 0;
    mclr(4'b1011, "R2 disable pins and btn");
    pin0_evt = 1; pin1_evt = 1; btn_evt = 1; idle(3, "R5 masked sources");
    pin0_evt = 0; pin1_evt = 0; btn_evt = 0;
    hwrst_evt = 1; idle(2, "R10 hw reset unmasked");
    hwrst_evt = 0; idle(1, "R10 idle");
    mset(4'b1111, "R1 re-enable");
    rtc_evt = 1; tick("R10 rtc bit1");
    rtc_evt = 0; tick("R10 idle");
    btn_evt = 1; tick("R10 button bit0");
    btn_evt = 0; tick("R10 idle");
    sclr(4'b0010, "R11 partial clear");
    src_clr_vld = 1; src_clr_bits = 4'b0001; btn_evt = 1;
    tick("R11 event beats clear"); src_clr_vld = 0; btn_evt = 0;
    sclr(4'hF, "R11 clear all");

    pm_state = 2'd1; latch_mode = 0;
    rtc_evt = 1; idle(2, "R7 R8 rtc state drop");
    rtc_evt = 0; idle(2, "R7 quiet");
    pm_state = 2'd2; idle(3, "R8 nothing released");

    pm_state = 2'd1; latch_mode = 1;
    btn_evt = 1; tick("R7 R9 hold button");
    btn_evt = 0; idle(3, "R7 R9 holding");
    pm_state = 2'd2; idle(3, "R9 released in OFF");
    sclr(4'hF, "R11 clear");

    pm_state = 2'd0;
    pin0_evt = 1; rtc_evt = 1; idle(3, "R12 run ignores");
    pin0_evt = 0; rtc_evt = 0;
    pm_state = 2'd3; hwrst_evt = 1; idle(2, "R12 code3 ignores");
    hwrst_evt = 0;
    pm_state = 2'd2; idle(3, "R12 nothing held");

    idle(2, "drain");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule